// File: doc/BRIEF.md
# Processor Low-Power Mode Controller with Wake Logic

This block is a finite-state power manager that sits in the always-on domain and moves a processor core between three operating states: ACTIVE, SLEEP and DEEP SLEEP. From its state it drives the core clock gate, a select for the always-on clock (fast, half rate or slow reference), the clock synthesizer enable, the core power-switch enable, the reverse body-bias enable, and the core isolation and reset controls.

The core asks for a low-power state with a single-cycle pulse when it executes its wait-for-interrupt instruction. The controller chooses the state itself. Active and idle time together fill a fixed duty period, so a counter of active cycles within the current period gives the idle time to expect. If that idle time exceeds a programmable threshold, the controller power-gates the core. Otherwise it only clock-gates the core. Masked hardware events wake the core. Power is restored through a fixed wait count, with no acknowledge from the switch. A wake event that arrives while the power-down sequence is still running cancels that sequence.

Top module: `pmc_top`

## Requirements
- R1: After reset the outputs show ACTIVE: core_clk_en=1, aon_clk_sel=0 (fast), synth_en=1, pwr_sw_en=1, rbb_en=0, core_iso=0, core_rst=0.
- R2: A wfi_req pulse in ACTIVE whose idle estimate is not above the threshold gives SLEEP on the next clock: core_clk_en=0, aon_clk_sel=1 (half rate), synth_en=1, pwr_sw_en=1, rbb_en=1, core_iso=0, core_rst=0.
- R3: A wfi_req pulse whose idle estimate is strictly above the threshold starts power-down. In the first cycle only the core clock is gated. In the second cycle core_iso=1 is added. From the third cycle the outputs show DEEP SLEEP: pwr_sw_en=0, synth_en=0, aon_clk_sel=2 (slow reference), rbb_en=1, core_iso=1, core_rst=1, core_clk_en=0.
- R4: The idle estimate is the duty period minus the number of ACTIVE cycles counted since the current period began. The period position and the active count both restart after every period length of cycles, and also when the period is written.
- R5: The threshold resets to 55 and the period resets to 1024. A write strobe (cfg_thr_we or cfg_per_we) loads cfg_wdata into the threshold or into the period.
- R6: An unmasked wake event during SLEEP returns the outputs to ACTIVE on the next clock.
- R7: An unmasked wake event in DEEP SLEEP runs the following exit sequence, one step per clock. First synth_en=1. Then aon_clk_sel=0 and rbb_en=0. Then pwr_sw_en=1, held for PWR_WAIT cycles (default 2) with isolation and reset still set. Then core_iso=0 and core_rst=0 with the clock still gated. Then ACTIVE.
- R8: An unmasked wake event in either power-down entry cycle cancels the sequence: ACTIVE follows on the next clock and pwr_sw_en never goes low.
- R9: A wake_evt bit whose wake_mask bit is 0 has no effect in SLEEP or DEEP SLEEP.
- R10: A wfi_req pulse that arrives together with an unmasked wake event leaves the controller in ACTIVE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wfi_req | input | 1 | Single-cycle sleep request from the core |
| wake_evt | input | NEV | Hardware wake events, one per bit |
| wake_mask | input | NEV | Per-event wake enable, 1 = enabled |
| cfg_thr_we | input | 1 | Write strobe for the idle threshold |
| cfg_per_we | input | 1 | Write strobe for the duty period |
| cfg_wdata | input | CW | Configuration write data |
| core_clk_en | output | 1 | Core clock enable (0 = gated) |
| aon_clk_sel | output | 2 | Always-on clock: 0 fast, 1 half rate, 2 slow reference |
| synth_en | output | 1 | Clock synthesizer enable |
| pwr_sw_en | output | 1 | Core power-switch enable |
| rbb_en | output | 1 | Reverse body-bias enable |
| core_iso | output | 1 | Core output isolation |
| core_rst | output | 1 | Core reset |

## Verification
The outputs decode the registered state directly, so any decision taken on a wfi_req or wake pulse appears one clock after the edge that sampled it. The bench drives each pulse on a falling edge and compares all eight output bits at the next falling edge. After that it steps one falling edge per clock through the entry and exit sequences, so each step of the power-up wait is checked in the cycle where it is due. The bench keeps its own count of active cycles in the period. It builds this count from the observed core_clk_en and from the reset and write strobes. It then sweeps idle estimates from two below to two above several thresholds, so the strict greater-than boundary is checked in the exact cycle of the request.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [3:0] {
    ST_ACTIVE   = 4'd0,
    ST_SLEEP    = 4'd1,
    ST_ENT_GATE = 4'd2,
    ST_ENT_ISO  = 4'd3,
    ST_DEEP     = 4'd4,
    ST_X_SYNTH  = 4'd5,
    ST_X_CLK    = 4'd6,
    ST_X_PWR    = 4'd7,
    ST_X_REL    = 4'd8
  } pmc_state_e;

  typedef enum logic [1:0] {
    CK_FAST = 2'd0,
    CK_HALF = 2'd1,
    CK_SLOW = 2'd2
  } aon_clk_e;

  typedef struct packed {
    logic     core_clk_en;
    aon_clk_e clk_sel;
    logic     synth_en;
    logic     pwr_sw_en;
    logic     rbb_en;
    logic     core_iso;
    logic     core_rst;
  } pmc_ctl_t;

  // Remaining cycles of the duty period once the active cycles are taken out.
  function automatic logic [31:0] idle_estimate(input logic [31:0] period,
                                                input logic [31:0] active);
    return (period > active) ? (period - active) : 32'd0;
  endfunction

  // Power gating only pays off when idle time is strictly above the threshold.
  function automatic logic pick_deep(input logic [31:0] idle,
                                     input logic [31:0] thr);
    return idle > thr;
  endfunction

  // Control outputs for each state.
  function automatic pmc_ctl_t ctl_for(input pmc_state_e st);
    pmc_ctl_t c;
    c = '{core_clk_en: 1'b0, clk_sel: CK_FAST, synth_en: 1'b1, pwr_sw_en: 1'b1,
          rbb_en: 1'b0, core_iso: 1'b0, core_rst: 1'b0};
    case (st)
      ST_ACTIVE:   c.core_clk_en = 1'b1;
      ST_SLEEP:    begin c.clk_sel = CK_HALF; c.rbb_en = 1'b1; end
      ST_ENT_GATE: ;
      ST_ENT_ISO:  c.core_iso = 1'b1;
      ST_DEEP:     begin
        c.clk_sel = CK_SLOW; c.synth_en = 1'b0; c.pwr_sw_en = 1'b0;
        c.rbb_en = 1'b1; c.core_iso = 1'b1; c.core_rst = 1'b1;
      end
      ST_X_SYNTH:  begin
        c.clk_sel = CK_SLOW; c.pwr_sw_en = 1'b0;
        c.rbb_en = 1'b1; c.core_iso = 1'b1; c.core_rst = 1'b1;
      end
      ST_X_CLK:    begin c.pwr_sw_en = 1'b0; c.core_iso = 1'b1; c.core_rst = 1'b1; end
      ST_X_PWR:    begin c.core_iso = 1'b1; c.core_rst = 1'b1; end
      ST_X_REL:    ;
      default:     c.core_clk_en = 1'b1;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pmc_cfg_regs.sv
module pmc_cfg_regs #(
  parameter int CW      = 12,
  parameter int THR_RST = 55,
  parameter int PER_RST = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          thr_we,
  input  logic          per_we,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] thr_q,
  output logic [CW-1:0] per_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q <= CW'(THR_RST);
      per_q <= CW'(PER_RST);
    end else begin
      if (thr_we) thr_q <= wdata;
      if (per_we) per_q <= wdata;
    end
  end

  // R5: a period write lands on the very next edge
  a_r5_per_load: assert property (@(posedge clk) disable iff (!rst_n)
    per_we |=> (per_q == $past(wdata)))
    else $error("period write not applied");

endmodule

// File: rtl/pmc_duty_meter.sv
module pmc_duty_meter #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          active,
  input  logic [CW-1:0] period,
  output logic [CW-1:0] idle_est
);

  logic [CW-1:0] pos_cnt;
  logic [CW-1:0] act_cnt;
  logic [CW-1:0] last_pos;
  logic          period_end;

  assign last_pos   = (period == '0) ? '0 : period - CW'(1);
  assign period_end = (pos_cnt >= last_pos);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      pos_cnt <= '0;
      act_cnt <= '0;
    end else if (period_end) begin
      pos_cnt <= '0;
      act_cnt <= '0;
    end else begin
      pos_cnt <= pos_cnt + CW'(1);
      act_cnt <= act_cnt + CW'(active);
    end
  end

  assign idle_est = CW'(pmc_pkg::idle_estimate(32'(period), 32'(act_cnt)));

  // R4: active cycles can never outrun elapsed cycles of the period
  a_r4_act_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    act_cnt <= pos_cnt)
    else $error("active count exceeds period position");

  // R4: the window restarts after its last cycle
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (period_end && !clr) |=> (act_cnt == '0))
    else $error("active count not cleared at period end");

endmodule

// File: rtl/pmc_wake_gate.sv
module pmc_wake_gate #(
  parameter int NEV = 4
) (
  input  logic [NEV-1:0] evt,
  input  logic [NEV-1:0] mask,
  output logic           wake_hit
);

  logic [NEV-1:0] live;

  for (genvar i = 0; i < NEV; i++) begin : g_ev
    assign live[i] = evt[i] & mask[i];
  end

  assign wake_hit = |live;

  // R9: a hit requires at least one enabled event bit
  always_comb begin
    a_r9_mask_gate: assert (!wake_hit || ((evt & mask) != '0))
      else $error("wake without enabled event");
  end

endmodule

// File: rtl/pmc_sequencer.sv
module pmc_sequencer
  import pmc_pkg::*;
#(
  parameter int PWR_WAIT = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wfi_req,
  input  logic     wake,
  input  logic     go_deep,
  output pmc_ctl_t ctl
);

  localparam int WW = (PWR_WAIT < 2) ? 1 : $clog2(PWR_WAIT);

  pmc_state_e    state, state_nx;
  logic [WW-1:0] wait_cnt;
  logic          wait_done;
  logic          sleep_take;
  logic          entry_abort;

  assign wait_done   = (wait_cnt == '0);
  assign sleep_take  = wfi_req && !wake;
  assign entry_abort = wake && (state == ST_ENT_GATE || state == ST_ENT_ISO);

  always_comb begin
    state_nx = state;
    case (state)
      ST_ACTIVE:   if (sleep_take) state_nx = go_deep ? ST_ENT_GATE : ST_SLEEP;
      ST_SLEEP:    if (wake) state_nx = ST_ACTIVE;
      ST_ENT_GATE: state_nx = wake ? ST_ACTIVE : ST_ENT_ISO;
      ST_ENT_ISO:  state_nx = wake ? ST_ACTIVE : ST_DEEP;
      ST_DEEP:     if (wake) state_nx = ST_X_SYNTH;
      ST_X_SYNTH:  state_nx = ST_X_CLK;
      ST_X_CLK:    state_nx = ST_X_PWR;
      ST_X_PWR:    if (wait_done) state_nx = ST_X_REL;
      ST_X_REL:    state_nx = ST_ACTIVE;
      default:     state_nx = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_ACTIVE;
      wait_cnt <= '0;
    end else begin
      state <= state_nx;
      if (state == ST_X_CLK)
        wait_cnt <= WW'(PWR_WAIT - 1);
      else if (state == ST_X_PWR && !wait_done)
        wait_cnt <= wait_cnt - WW'(1);
    end
  end

  assign ctl = ctl_for(state);

  // R3: whenever power is off the core is isolated, held in reset and gated
  a_r3_off_safe: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.pwr_sw_en |-> (ctl.core_iso && ctl.core_rst && !ctl.core_clk_en))
    else $error("power off without isolation");

  // R8: wake during entry returns to ACTIVE with power kept
  a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
    entry_abort |=> (state == ST_ACTIVE && ctl.pwr_sw_en))
    else $error("entry not aborted");

  // R10: a pending wake wins over a simultaneous request
  a_r10_wfi_vs_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACTIVE && wfi_req && wake) |=> (state == ST_ACTIVE))
    else $error("sleep taken with wake pending");

  // R6: wake in SLEEP ungates on the next edge
  a_r6_sleep_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP && wake) |=> ctl.core_clk_en)
    else $error("slow wake from sleep");

  // R7: reset is released only with power on and the clock still gated
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl.core_rst) |-> (ctl.pwr_sw_en && !ctl.core_clk_en && ctl.synth_en))
    else $error("reset released out of order");

  // R7: core clock returns only with power on and reset released
  a_r7_ungate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl.core_clk_en) |-> (ctl.pwr_sw_en && !ctl.core_rst && !ctl.core_iso))
    else $error("clock ungated too early");

endmodule

// File: rtl/pmc_top.sv
module pmc_top #(
  parameter int NEV      = 4,
  parameter int CW       = 12,
  parameter int THR_RST  = 55,
  parameter int PER_RST  = 1024,
  parameter int PWR_WAIT = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wfi_req,
  input  logic [NEV-1:0] wake_evt,
  input  logic [NEV-1:0] wake_mask,
  input  logic           cfg_thr_we,
  input  logic           cfg_per_we,
  input  logic [CW-1:0]  cfg_wdata,
  output logic           core_clk_en,
  output logic [1:0]     aon_clk_sel,
  output logic           synth_en,
  output logic           pwr_sw_en,
  output logic           rbb_en,
  output logic           core_iso,
  output logic           core_rst
);

  import pmc_pkg::*;

  logic [CW-1:0] thr_q;
  logic [CW-1:0] per_q;
  logic [CW-1:0] idle_est;
  logic          wake_hit;
  logic          go_deep;
  pmc_ctl_t      ctl;

  pmc_cfg_regs #(.CW(CW), .THR_RST(THR_RST), .PER_RST(PER_RST)) u_cfg (
    .clk(clk), .rst_n(rst_n), .thr_we(cfg_thr_we), .per_we(cfg_per_we),
    .wdata(cfg_wdata), .thr_q(thr_q), .per_q(per_q));

  pmc_duty_meter #(.CW(CW)) u_meter (
    .clk(clk), .rst_n(rst_n), .clr(cfg_per_we), .active(ctl.core_clk_en),
    .period(per_q), .idle_est(idle_est));

  pmc_wake_gate #(.NEV(NEV)) u_wake (
    .evt(wake_evt), .mask(wake_mask), .wake_hit(wake_hit));

  assign go_deep = pick_deep(32'(idle_est), 32'(thr_q));

  pmc_sequencer #(.PWR_WAIT(PWR_WAIT)) u_seq (
    .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .wake(wake_hit),
    .go_deep(go_deep), .ctl(ctl));

  assign core_clk_en = ctl.core_clk_en;
  assign aon_clk_sel = ctl.clk_sel;
  assign synth_en    = ctl.synth_en;
  assign pwr_sw_en   = ctl.pwr_sw_en;
  assign rbb_en      = ctl.rbb_en;
  assign core_iso    = ctl.core_iso;
  assign core_rst    = ctl.core_rst;

  // R2: when the core is gated but powered, synthesizer stays on
  a_r2_sleep_synth: assert property (@(posedge clk) disable iff (!rst_n)
    (aon_clk_sel == 2'd1) |-> (synth_en && pwr_sw_en && rbb_en && !core_clk_en))
    else $error("half-rate clock outside sleep");

endmodule

// File: tb/pmc_top_tb.sv
`timescale 1ns/1ps
module pmc_top_tb;

  localparam int NEV = 4;
  localparam int CW  = 12;
  localparam int PW  = 2;

  localparam logic [7:0] E_ACT  = 8'b1001_1000;
  localparam logic [7:0] E_SLP  = 8'b0011_1100;
  localparam logic [7:0] E_GATE = 8'b0001_1000;
  localparam logic [7:0] E_ISO  = 8'b0001_1010;
  localparam logic [7:0] E_DEEP = 8'b0100_0111;
  localparam logic [7:0] E_XSYN = 8'b0101_0111;
  localparam logic [7:0] E_XCLK = 8'b0001_0011;
  localparam logic [7:0] E_XPWR = 8'b0001_1011;
  localparam logic [7:0] E_XREL = 8'b0001_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wfi_req = 1'b0;
  logic [NEV-1:0] wake_evt = '0;
  logic [NEV-1:0] wake_mask = '1;
  logic cfg_thr_we = 1'b0;
  logic cfg_per_we = 1'b0;
  logic [CW-1:0] cfg_wdata = '0;
  logic core_clk_en, synth_en, pwr_sw_en, rbb_en, core_iso, core_rst;
  logic [1:0] aon_clk_sel;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int m_pos, m_act, m_per, m_thr;

  always #4 clk = ~clk;

  pmc_top #(.NEV(NEV), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .wake_evt(wake_evt),
    .wake_mask(wake_mask), .cfg_thr_we(cfg_thr_we), .cfg_per_we(cfg_per_we),
    .cfg_wdata(cfg_wdata), .core_clk_en(core_clk_en), .aon_clk_sel(aon_clk_sel),
    .synth_en(synth_en), .pwr_sw_en(pwr_sw_en), .rbb_en(rbb_en),
    .core_iso(core_iso), .core_rst(core_rst));

  // Duty-window bookkeeping from the requirement text (R4, R5), driven by
  // the observed clock-enable output and the strobes before each edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_pos = 0; m_act = 0; m_per = 1024; m_thr = 55;
    end else begin
      if (cfg_thr_we) m_thr = int'(cfg_wdata);
      if (cfg_per_we) begin
        m_per = int'(cfg_wdata); m_pos = 0; m_act = 0;
      end else if (m_pos == m_per - 1) begin
        m_pos = 0; m_act = 0;
      end else begin
        m_pos = m_pos + 1;
        if (core_clk_en) m_act = m_act + 1;
      end
    end
  end

  function automatic logic [7:0] obs();
    return {core_clk_en, aon_clk_sel, synth_en, pwr_sw_en, rbb_en, core_iso, core_rst};
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] exp);
    logic [7:0] got;
    got = obs();
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic write_thr(input int v);
    cfg_wdata = CW'(v); cfg_thr_we = 1'b1; tick(); cfg_thr_we = 1'b0;
  endtask

  task automatic write_per(input int v);
    cfg_wdata = CW'(v); cfg_per_we = 1'b1; tick(); cfg_per_we = 1'b0;
  endtask

  task automatic wait_act(input int t);
    while (m_act != t) tick();
  endtask

  // Request sleep; the first state after the request edge is checked.
  task automatic request(input string req, input bit exp_deep);
    wfi_req = 1'b1; tick(); wfi_req = 1'b0;
    chk(req, exp_deep ? E_GATE : E_SLP);
  endtask

  task automatic wake_pulse(input int idx);
    wake_evt[idx] = 1'b1; tick(); wake_evt = '0;
  endtask

  task automatic finish_entry();
    tick(); chk("R3 isolate", E_ISO);
    tick(); chk("R3 deep", E_DEEP);
  endtask

  task automatic deep_exit();
    wake_pulse(1);
    chk("R7 synth on", E_XSYN);
    tick(); chk("R7 clock back", E_XCLK);
    for (int i = 0; i < PW; i++) begin
      tick(); chk("R7 power wait", E_XPWR);
    end
    tick(); chk("R7 release", E_XREL);
    tick(); chk("R7 active", E_ACT);
  endtask

  initial begin
    #(8ns * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int idle;
    bit ed;
    int thrs[3];
    thrs = '{5, 17, 40};

    rst_n = 1'b0;
    repeat (3) tick();
    chk("R1 reset outputs", E_ACT);
    rst_n = 1'b1;
    tick();
    chk("R1 after release", E_ACT);

    // R5: defaults 1024/55; early request leaves a long idle estimate
    repeat (3) tick();
    ed = (m_per - m_act) > m_thr;
    request("R5 default early", ed);
    if (ed) begin
      finish_entry();
      // R9: masked event bit 0 must not wake
      wake_mask = 4'b1110;
      wake_pulse(0);
      chk("R9 masked in deep", E_DEEP);
      tick(); chk("R9 still deep", E_DEEP);
      wake_mask = '1;
      deep_exit();
    end

    // R5: default threshold boundary, idle 56 -> deep, idle 55 -> sleep
    write_per(1024);
    wait_act(968);
    request("R5 idle 56 deep", 1'b1);
    finish_entry();
    deep_exit();
    write_per(1024);
    wait_act(969);
    request("R5 idle 55 sleep", 1'b0);
    wake_mask = 4'b1101;
    wake_pulse(1);
    chk("R9 masked in sleep", E_SLP);
    wake_mask = '1;
    wake_pulse(3);
    chk("R6 sleep wake", E_ACT);

    // R2/R3 sweep around each threshold with a 64-cycle period
    for (int ti = 0; ti < 3; ti++) begin
      write_thr(thrs[ti]);
      for (int d = -2; d <= 2; d++) begin
        write_per(64);
        idle = thrs[ti] + d;
        wait_act(64 - idle);
        ed = idle > thrs[ti];
        request(ed ? "R3 sweep deep" : "R2 sweep sleep", ed);
        if (!ed) begin
          wake_pulse(0);
          chk("R6 sweep wake", E_ACT);
        end else if (d == 2) begin
          wake_pulse(2);
          chk("R8 abort at gate", E_ACT);
        end else begin
          finish_entry();
          deep_exit();
        end
      end
    end

    // R8: abort in the isolation cycle
    write_thr(10);
    write_per(64);
    wait_act(20);
    request("R8 entry", 1'b1);
    tick(); chk("R8 isolate", E_ISO);
    wake_pulse(0);
    chk("R8 abort at isolate", E_ACT);

    // R10: request together with a live wake event
    wfi_req = 1'b1; wake_evt[1] = 1'b1;
    tick();
    wfi_req = 1'b0; wake_evt = '0;
    chk("R10 wake beats request", E_ACT);

    // R4: window restart; after a wrap only 2 active cycles count
    write_thr(12);
    write_per(16);
    repeat (17) tick();
    wait_act(2);
    request("R4 after wrap deep", 1'b1);
    finish_entry();
    deep_exit();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule